// File: doc/BRIEF.md
# Two-Queue Conversion Sequencer

This block decides which of two command queues may use a single shared converter. Each queue is a run of conversion command words in a small command memory outside the block. Queue 1 begins at address 0 and queue 2 begins at a parameterised base address. Each word carries a channel number, a pause flag and an end-of-queue flag. A trigger pulse starts a queue or continues it. The sequencer then fetches words one at a time and offers each channel to the converter. When the converter reports that the conversion is done, the sequencer moves on to the next word.

Queue 1 always wins access to the converter. A queue 2 trigger that arrives while queue 1 owns the converter is held as pending. A queue 1 trigger that arrives while queue 2 is running aborts the conversion in flight and parks queue 2 as suspended. Queue 2 picks up again as soon as queue 1 pauses or completes. A mode input chooses where it picks up: at its first word, or at the first word of the sub-queue that was interrupted. Pause flags split either queue into sub-queues, and each sub-queue needs its own trigger.

The converter request is a valid/ready stream. Once `conv_valid_o` is high, it and the channel stay unchanged until `conv_ready_i` accepts them. The one exception is a queue 1 pre-emption, which withdraws a queue 2 request. Only one conversion is outstanding at a time. The command memory read is combinational: `ccw_data_i` must reflect `ccw_addr_o` within the same cycle.

Top module: `cq_seq`

## Requirements
- R1: After reset, both queue states read idle (0), both overrun flags and both completion flags are low, and `conv_valid_o` is low.
- R2: A trigger for a queue in the idle or paused state, with no higher-priority conflict, makes that queue active (state 1) in the next cycle and presents its current word address on `ccw_addr_o`. From idle, that address is the queue's base.
- R3: A queue 2 trigger that arrives while queue 1 is, or is becoming, active moves queue 2 to pending (state 3). Queue 2 gets no conversions while queue 1 is active. It becomes active in the cycle after queue 1 pauses or completes.
- R4: Triggers for both queues in the same cycle, with both idle, give queue 1 active and queue 2 pending.
- R5: A queue 2 trigger while queue 2 is active, pending or suspended sets the queue 2 overrun flag. A queue 1 trigger while queue 1 is active sets the queue 1 overrun flag. Both flags stay high until `ovr_clr_i` is asserted.
- R6: A queue 1 trigger while queue 2 is active makes queue 2 suspended (state 4) in the next cycle. If a queue 2 conversion was in flight or being accepted, `conv_abort_o` pulses for that cycle and any done for that conversion is discarded.
- R7: A suspended queue 2 becomes active in the cycle after queue 1 completes or pauses.
- R8: A word is encoded as {eoq, pause, channel[CH_W-1:0]}. When a word with its pause flag set finishes, the queue goes paused (state 2) and issues nothing more. The next trigger continues from the following word.
- R9: When a word with its end-of-queue flag set finishes, the queue returns to idle, its completion flag is high for exactly one cycle, and the next trigger restarts the queue at its base.
- R10: When `q2_resume_sub_i` is 0, a suspended queue 2 restarts at its base address. When it is 1, queue 2 restarts at the first word of the sub-queue it was in.
- R11: `conv_chan_o` carries the channel field of the word at `ccw_addr_o`. A request not yet accepted keeps `conv_valid_o`, `conv_chan_o` and `ccw_addr_o` stable unless a queue 1 trigger pre-empts it, and no new request is raised until the current conversion completes or is aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q1_trig_i | input | 1 | Queue 1 trigger pulse |
| q2_trig_i | input | 1 | Queue 2 trigger pulse |
| q2_resume_sub_i | input | 1 | Queue 2 restart point: 0 base, 1 interrupted sub-queue |
| ovr_clr_i | input | 1 | Clears both overrun flags |
| ccw_addr_o | output | AW | Command memory read address |
| ccw_data_i | input | CH_W+2 | Command word at ccw_addr_o |
| conv_valid_o | output | 1 | Conversion request valid |
| conv_ready_i | input | 1 | Converter accepts the request |
| conv_chan_o | output | CH_W | Channel to convert |
| conv_done_i | input | 1 | Outstanding conversion finished |
| conv_abort_o | output | 1 | Outstanding queue 2 conversion cancelled |
| q1_state_o | output | 3 | Queue 1 state (0 idle, 1 active, 2 paused, 3 pending, 4 suspended) |
| q2_state_o | output | 3 | Queue 2 state, same encoding |
| q1_ovr_o | output | 1 | Queue 1 sticky trigger overrun |
| q2_ovr_o | output | 1 | Queue 2 sticky trigger overrun |
| q1_cmpl_o | output | 1 | Queue 1 completion pulse |
| q2_cmpl_o | output | 1 | Queue 2 completion pulse |

## Verification
Several properties are checked on every cycle:
- the two queues are never active together;
- an abort only occurs with queue 2 suspended under an active queue 1;
- overrun flags hold until cleared;
- a completion pulse coincides with idle;
- a stalled request keeps its channel;
- simultaneous triggers give the queue 1 / pending split.

Some behaviours only show up over a whole scenario, so the bench's scoreboard covers them: the exact order of channels the converter receives, the restart point chosen by the resume mode, continuation after a pause, and the wake of a pending or suspended queue 2 when queue 1 finishes.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;
  typedef enum logic [2:0] {
    QS_IDLE    = 3'd0,
    QS_ACTIVE  = 3'd1,
    QS_PAUSED  = 3'd2,
    QS_PENDING = 3'd3,
    QS_SUSPEND = 3'd4
  } qstate_e;
endpackage

// File: rtl/cq_queue.sv
`timescale 1ns/1ps
// Per-queue state, word pointer, sub-queue start, overrun flag and completion pulse.
module cq_queue
  import cq_pkg::*;
#(
  parameter int AW   = 5,
  parameter int BASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          pend_i,
  input  logic          susp_i,
  input  logic          wake_i,
  input  logic          adv_i,
  input  logic          adv_pause_i,
  input  logic          adv_eoq_i,
  input  logic          resume_sub_i,
  input  logic          ovr_set_i,
  input  logic          ovr_clr_i,
  output qstate_e       state_o,
  output logic [AW-1:0] ptr_o,
  output logic          ovr_o,
  output logic          cmpl_o
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);

  qstate_e       state_q;
  logic [AW-1:0] ptr_q, sub_q;
  logic          ovr_q, cmpl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= QS_IDLE;
      ptr_q   <= BASE_A;
      sub_q   <= BASE_A;
      ovr_q   <= 1'b0;
      cmpl_q  <= 1'b0;
    end else begin
      cmpl_q <= 1'b0;
      if (ovr_set_i)      ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;

      if (adv_i) begin
        if (adv_eoq_i) begin
          state_q <= QS_IDLE;
          ptr_q   <= BASE_A;
          sub_q   <= BASE_A;
          cmpl_q  <= 1'b1;
        end else if (adv_pause_i) begin
          state_q <= QS_PAUSED;
          ptr_q   <= ptr_q + 1'b1;
          sub_q   <= ptr_q + 1'b1;
        end else begin
          ptr_q   <= ptr_q + 1'b1;
        end
      end else if (susp_i) begin
        state_q <= QS_SUSPEND;
        ptr_q   <= resume_sub_i ? sub_q : BASE_A;
      end else if (start_i || wake_i) begin
        state_q <= QS_ACTIVE;
      end else if (pend_i) begin
        state_q <= QS_PENDING;
      end
    end
  end

  assign state_o = state_q;
  assign ptr_o   = ptr_q;
  assign ovr_o   = ovr_q;
  assign cmpl_o  = cmpl_q;
endmodule

// File: rtl/cq_conv.sv
`timescale 1ns/1ps
// Single-outstanding conversion tracker: request, acceptance, done and abort.
module cq_conv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       owner_i,
  input  logic       ccw_pause_i,
  input  logic       ccw_eoq_i,
  input  logic       preempt_i,
  output logic       conv_valid_o,
  input  logic       conv_ready_i,
  input  logic       conv_done_i,
  output logic       conv_abort_o,
  output logic [1:0] adv_o,
  output logic       adv_pause_o,
  output logic       adv_eoq_o
);
  logic busy_q, own_q, pause_q, eoq_q, abort_q;
  logic hs, done_ok;

  assign conv_valid_o = req_i && !busy_q;
  assign hs           = conv_valid_o && conv_ready_i;
  assign done_ok      = conv_done_i && busy_q && !(preempt_i && own_q);
  assign adv_o        = {done_ok && own_q, done_ok && !own_q};
  assign adv_pause_o  = pause_q;
  assign adv_eoq_o    = eoq_q;
  assign conv_abort_o = abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      own_q   <= 1'b0;
      pause_q <= 1'b0;
      eoq_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= preempt_i && ((busy_q && own_q) || (hs && owner_i));
      if (preempt_i || done_ok) begin
        busy_q <= 1'b0;
      end else if (hs) begin
        busy_q  <= 1'b1;
        own_q   <= owner_i;
        pause_q <= ccw_pause_i;
        eoq_q   <= ccw_eoq_i;
      end
    end
  end
endmodule

// File: rtl/cq_seq.sv
`timescale 1ns/1ps
// Two-queue sequencer sharing one converter, queue 1 with strict priority.
module cq_seq
  import cq_pkg::*;
#(
  parameter int AW      = 5,
  parameter int CH_W    = 4,
  parameter int Q2_BASE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            q1_trig_i,
  input  logic            q2_trig_i,
  input  logic            q2_resume_sub_i,
  input  logic            ovr_clr_i,
  output logic [AW-1:0]   ccw_addr_o,
  input  logic [CH_W+1:0] ccw_data_i,
  output logic            conv_valid_o,
  input  logic            conv_ready_i,
  output logic [CH_W-1:0] conv_chan_o,
  input  logic            conv_done_i,
  output logic            conv_abort_o,
  output logic [2:0]      q1_state_o,
  output logic [2:0]      q2_state_o,
  output logic            q1_ovr_o,
  output logic            q2_ovr_o,
  output logic            q1_cmpl_o,
  output logic            q2_cmpl_o
);
  localparam int NQ = 2;
  localparam int PAUSE_BIT = CH_W;
  localparam int EOQ_BIT   = CH_W + 1;

  qstate_e       st  [NQ];
  logic [AW-1:0] ptr [NQ];
  logic [NQ-1:0] act, idl, start_v, pend_v, susp_v, wake_v, ovr_set_v, ovr_v, cmpl_v, adv_v, resume_v;
  logic          adv_pause, adv_eoq, q1_leave, q1_busy_nx, preempt;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign act[g] = (st[g] == QS_ACTIVE);
    assign idl[g] = (st[g] == QS_IDLE) || (st[g] == QS_PAUSED);
    cq_queue #(.AW(AW), .BASE(g == 0 ? 0 : Q2_BASE)) u_q (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_v[g]), .pend_i(pend_v[g]), .susp_i(susp_v[g]), .wake_i(wake_v[g]),
      .adv_i(adv_v[g]), .adv_pause_i(adv_pause), .adv_eoq_i(adv_eoq),
      .resume_sub_i(resume_v[g]), .ovr_set_i(ovr_set_v[g]), .ovr_clr_i(ovr_clr_i),
      .state_o(st[g]), .ptr_o(ptr[g]), .ovr_o(ovr_v[g]), .cmpl_o(cmpl_v[g])
    );
  end

  // Arbitration between the two queues
  always_comb begin
    q1_leave   = adv_v[0] && (adv_pause || adv_eoq);
    start_v    = '0;
    pend_v     = '0;
    susp_v     = '0;
    wake_v     = '0;
    ovr_set_v  = '0;
    start_v[0] = q1_trig_i && idl[0];
    ovr_set_v[0] = q1_trig_i && !idl[0];
    q1_busy_nx = (act[0] && !q1_leave) || start_v[0];
    start_v[1] = q2_trig_i && idl[1] && !q1_busy_nx;
    pend_v[1]  = q2_trig_i && idl[1] && q1_busy_nx;
    ovr_set_v[1] = q2_trig_i && !idl[1];
    susp_v[1]  = start_v[0] && act[1];
    wake_v[1]  = q1_leave && ((st[1] == QS_PENDING) || (st[1] == QS_SUSPEND));
    preempt    = susp_v[1];
  end

  assign resume_v    = {q2_resume_sub_i, 1'b0};
  assign ccw_addr_o  = act[0] ? ptr[0] : ptr[1];
  assign conv_chan_o = ccw_data_i[CH_W-1:0];

  cq_conv u_conv (
    .clk(clk), .rst_n(rst_n),
    .req_i(|act), .owner_i(!act[0]),
    .ccw_pause_i(ccw_data_i[PAUSE_BIT]), .ccw_eoq_i(ccw_data_i[EOQ_BIT]),
    .preempt_i(preempt),
    .conv_valid_o(conv_valid_o), .conv_ready_i(conv_ready_i),
    .conv_done_i(conv_done_i), .conv_abort_o(conv_abort_o),
    .adv_o(adv_v), .adv_pause_o(adv_pause), .adv_eoq_o(adv_eoq)
  );

  assign q1_state_o = st[0];
  assign q2_state_o = st[1];
  assign q1_ovr_o   = ovr_v[0];
  assign q2_ovr_o   = ovr_v[1];
  assign q1_cmpl_o  = cmpl_v[0];
  assign q2_cmpl_o  = cmpl_v[1];
endmodule

// File: rtl/cq_seq_chk.sv
`timescale 1ns/1ps
module cq_seq_chk #(
  parameter int AW   = 5,
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            q1_trig_i,
  input logic            q2_trig_i,
  input logic            ovr_clr_i,
  input logic [AW-1:0]   ccw_addr_o,
  input logic            conv_valid_o,
  input logic            conv_ready_i,
  input logic [CH_W-1:0] conv_chan_o,
  input logic            conv_abort_o,
  input logic [2:0]      q1_state_o,
  input logic [2:0]      q2_state_o,
  input logic            q1_ovr_o,
  input logic            q2_ovr_o,
  input logic            q1_cmpl_o,
  input logic            q2_cmpl_o
);
  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1_state_o == 3'd1 && q2_state_o == 3'd1)); // R3
  AST_BOTH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_trig_i && q2_trig_i && q1_state_o == 3'd0 && q2_state_o == 3'd0)
    |=> (q1_state_o == 3'd1 && q2_state_o == 3'd3)); // R4
  AST_Q1_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_trig_i && q1_state_o == 3'd1) |=> q1_ovr_o); // R5
  AST_Q1_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q1_ovr_o && !ovr_clr_i) |=> q1_ovr_o); // R5
  AST_Q2_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q2_ovr_o && !ovr_clr_i) |=> q2_ovr_o); // R5
  AST_ABORT_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |-> (q2_state_o == 3'd4 && q1_state_o == 3'd1)); // R6
  AST_Q1_CMPL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    q1_cmpl_o |-> q1_state_o == 3'd0); // R9
  AST_Q2_CMPL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    q2_cmpl_o |-> q2_state_o == 3'd0); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid_o && !conv_ready_i && !q1_trig_i)
    |=> (conv_valid_o && $stable(conv_chan_o) && $stable(ccw_addr_o))); // R11
endmodule

bind cq_seq cq_seq_chk #(.AW(AW), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .q1_trig_i(q1_trig_i), .q2_trig_i(q2_trig_i),
  .ovr_clr_i(ovr_clr_i), .ccw_addr_o(ccw_addr_o), .conv_valid_o(conv_valid_o),
  .conv_ready_i(conv_ready_i), .conv_chan_o(conv_chan_o), .conv_abort_o(conv_abort_o),
  .q1_state_o(q1_state_o), .q2_state_o(q2_state_o), .q1_ovr_o(q1_ovr_o),
  .q2_ovr_o(q2_ovr_o), .q1_cmpl_o(q1_cmpl_o), .q2_cmpl_o(q2_cmpl_o)
);

// File: tb/cq_seq_tb_top.sv
`timescale 1ns/1ps
module cq_seq_tb_top;
  localparam int AW = 5, CH_W = 4, Q2B = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q1_trig = 1'b0, q2_trig = 1'b0, q2_res = 1'b0, ovr_clr = 1'b0;
  logic conv_ready = 1'b1, conv_done = 1'b0;
  logic [AW-1:0] ccw_addr;
  logic [CH_W+1:0] ccw_data;
  logic conv_valid, conv_abort;
  logic [CH_W-1:0] conv_chan;
  logic [2:0] q1_st, q2_st;
  logic q1_ovr, q2_ovr, q1_cmpl, q2_cmpl;
  logic [CH_W+1:0] mem [32];

  always #4 clk = ~clk;

  assign ccw_data = mem[ccw_addr];

  cq_seq #(.AW(AW), .CH_W(CH_W), .Q2_BASE(Q2B)) dut_i (
    .clk(clk), .rst_n(rst_n), .q1_trig_i(q1_trig), .q2_trig_i(q2_trig),
    .q2_resume_sub_i(q2_res), .ovr_clr_i(ovr_clr), .ccw_addr_o(ccw_addr),
    .ccw_data_i(ccw_data), .conv_valid_o(conv_valid), .conv_ready_i(conv_ready),
    .conv_chan_o(conv_chan), .conv_done_i(conv_done), .conv_abort_o(conv_abort),
    .q1_state_o(q1_st), .q2_state_o(q2_st), .q1_ovr_o(q1_ovr), .q2_ovr_o(q2_ovr),
    .q1_cmpl_o(q1_cmpl), .q2_cmpl_o(q2_cmpl)
  );

  int total = 0, bad = 0, cnt = 0;
  int exp_q[$];
  string cur_req = "R1";

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CH_W+1:0] mk(int ch, bit p, bit e);
    return {e, p, CH_W'(ch)};
  endfunction

  // Converter model and scoreboard monitor, sampled mid low phase
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      conv_done = 1'b0;
      if (conv_abort) cnt = 0;
      else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) conv_done = 1'b1;
      end
      if (conv_valid && conv_ready) begin
        if (exp_q.size() == 0) chk(1'b0, cur_req, int'(conv_chan), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(conv_chan) == e, cur_req, int'(conv_chan), e);
        end
        cnt = 4;
      end
    end
  end

  task automatic wait_st(bit q2, int v, string req);
    for (int i = 0; i < 300; i++) begin
      if ((q2 ? int'(q2_st) : int'(q1_st)) == v) break;
      @(negedge clk);
    end
    chk((q2 ? int'(q2_st) : int'(q1_st)) == v, req, q2 ? int'(q2_st) : int'(q1_st), v);
  endtask

  task automatic wait_cmpl(bit q2, string req);
    for (int i = 0; i < 300; i++) begin
      if (q2 ? q2_cmpl : q1_cmpl) break;
      @(negedge clk);
    end
    chk(q2 ? q2_cmpl : q1_cmpl, req, 0, 1);
  endtask

  task automatic wait_busy2();
    for (int i = 0; i < 300; i++) begin
      if (q2_st == 3'd1 && !conv_valid) break;
      @(negedge clk);
    end
    chk(q2_st == 3'd1 && !conv_valid, "R6", int'(q2_st), 1);
  endtask

  task automatic pulse(bit q2);
    if (q2) q2_trig = 1'b1; else q1_trig = 1'b1;
    @(negedge clk);
    q1_trig = 1'b0;
    q2_trig = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    mem[0] = mk(1, 0, 0);  mem[1] = mk(2, 1, 0);
    mem[2] = mk(3, 0, 0);  mem[3] = mk(4, 0, 1);
    mem[16] = mk(8, 0, 0); mem[17] = mk(9, 1, 0);
    mem[18] = mk(10, 0, 0); mem[19] = mk(11, 0, 0); mem[20] = mk(12, 0, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(q1_st == 0 && q2_st == 0, "R1", int'(q1_st), 0);
    chk(!conv_valid && !q1_ovr && !q2_ovr && !q1_cmpl && !q2_cmpl, "R1", int'(conv_valid), 0);

    // R2 / R11: start with converter stalled
    cur_req = "R11";
    exp_q.push_back(1); exp_q.push_back(2);
    conv_ready = 1'b0;
    pulse(1'b0);
    chk(q1_st == 1, "R2", int'(q1_st), 1);
    chk(ccw_addr == 0, "R2", int'(ccw_addr), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(conv_valid && conv_chan == 1, "R11", int'(conv_chan), 1);
    end
    conv_ready = 1'b1;
    wait_st(1'b0, 2, "R8");
    repeat (2) @(negedge clk);
    chk(!conv_valid, "R8", int'(conv_valid), 0);

    // R9: continue after pause, reach end of queue
    cur_req = "R9";
    exp_q.push_back(3); exp_q.push_back(4);
    pulse(1'b0);
    wait_cmpl(1'b0, "R9");
    chk(q1_st == 0, "R9", int'(q1_st), 0);
    @(negedge clk);
    chk(!q1_cmpl, "R9", int'(q1_cmpl), 0);

    // R4 / R3 / R5: simultaneous triggers, extra queue 2 trigger while pending
    cur_req = "R3";
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(8); exp_q.push_back(9);
    q1_trig = 1'b1; q2_trig = 1'b1;
    @(negedge clk);
    q1_trig = 1'b0;
    chk(q1_st == 1, "R4", int'(q1_st), 1);
    chk(q2_st == 3, "R4", int'(q2_st), 3);
    chk(ccw_addr == 0, "R9", int'(ccw_addr), 0);
    @(negedge clk);
    q2_trig = 1'b0;
    chk(q2_ovr, "R5", int'(q2_ovr), 1);
    wait_st(1'b0, 2, "R3");
    chk(q2_st == 1, "R3", int'(q2_st), 1);
    wait_st(1'b1, 2, "R8");
    chk(q2_ovr, "R5", int'(q2_ovr), 1);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    chk(!q2_ovr, "R5", int'(q2_ovr), 0);

    // R6 / R7 / R10: pre-empt queue 2 in its second sub-queue, resume at sub-queue
    cur_req = "R6";
    q2_res = 1'b1;
    exp_q.push_back(10);
    pulse(1'b1);
    wait_busy2();
    exp_q.push_back(3); exp_q.push_back(4);
    exp_q.push_back(10); exp_q.push_back(11); exp_q.push_back(12);
    pulse(1'b0);
    chk(q2_st == 4, "R6", int'(q2_st), 4);
    chk(conv_abort, "R6", int'(conv_abort), 1);
    pulse(1'b1);
    chk(q2_ovr, "R5", int'(q2_ovr), 1);
    chk(q2_st == 4, "R6", int'(q2_st), 4);
    cur_req = "R7";
    wait_cmpl(1'b0, "R7");
    chk(q2_st == 1, "R7", int'(q2_st), 1);
    chk(ccw_addr == 18, "R10", int'(ccw_addr), 18);
    cur_req = "R10";
    wait_cmpl(1'b1, "R10");

    // R10: resume mode 0 restarts queue 2 at its base
    q2_res = 1'b0;
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    exp_q.push_back(8); exp_q.push_back(9);
    pulse(1'b1);
    chk(ccw_addr == 16, "R2", int'(ccw_addr), 16);
    wait_st(1'b1, 2, "R8");
    exp_q.push_back(1); exp_q.push_back(2);
    pulse(1'b0);
    wait_st(1'b0, 2, "R8");
    exp_q.push_back(10);
    pulse(1'b1);
    wait_busy2();
    exp_q.push_back(3); exp_q.push_back(4); exp_q.push_back(8); exp_q.push_back(9);
    pulse(1'b0);
    chk(conv_abort, "R6", int'(conv_abort), 1);
    wait_cmpl(1'b0, "R7");
    chk(ccw_addr == 16, "R10", int'(ccw_addr), 16);
    wait_st(1'b1, 2, "R10");
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R11", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule